// File: doc/BRIEF.md
# Dual-Oscillator System Clock Source Controller

This block holds the four-bit control word that decides where the system clock comes from. The clock can come from a fast main oscillator or from a slow sub-oscillator. The same word also decides whether the main oscillator is powered. A CPU-style write port loads the word. The block checks every write against a set of switching rules before accepting it, so that software cannot reach a state that halts the system clock. A write that breaks a rule is dropped, the stored word keeps its old value, and a sticky error flag is raised. The flag stays set until software clears it.

The oscillators and the clock multiplexer cells are not modelled. Each of the two clocks is represented by a phase-high input (`main_ph`, `sub_ph`). The sub-oscillator is also represented by a tick strobe (`sub_tick`). Moving from the slow clock back to the fast clock takes three steps:

1. Re-power the main oscillator.
2. Wait a programmable number of sub-oscillator ticks, until `main_ready` rises.
3. Select the main oscillator.

Whenever the select changes, the registered select output moves only at an edge where both clock phases are low. The main oscillator is powered down only once the select has really reached the sub-oscillator.

Top module: `clksw_ctrl`

## Requirements
- R1: While reset is active, and after it, `ctrl_q`=0, `clk_sel`=0, `main_osc_en`=1, `main_ready`=1 and `wr_err`=0.
- R2: `ctrl_q` bit 0 is the requested source (0 main, 1 sub). Bit 1 is main power-down (1 = off). Bit 2 drives `wdt_tap_sel` (0 selects system clock /1024, 1 selects /16384). Bit 3 drives `div_len12` (1 = 12-bit length, 0 = 13-bit). An accepted write appears on `ctrl_q` one clock after it.
- R3: A rejected write leaves `ctrl_q` unchanged and sets `wr_err`. `wr_err` stays set until a cycle with `err_clr` high and no rejected write. A rejected write in the same cycle as `err_clr` leaves `wr_err` at 1.
- R4: A write whose bit 0 and bit 1 both differ from the stored word is rejected.
- R5: A write whose bits 1:0 equal binary 10 (main powered down while still selected) is rejected. Bits 1:0 of `ctrl_q` never hold 10.
- R6: A write that changes bit 0 from 1 to 0 while `main_ready` is 0 is rejected.
- R7: `main_ready` drops to 0 one clock after an accepted write clears bit 1. It is also 0 from the second clock after bit 1 is set. With bit 1 clear, it rises after `STAB_TICKS` cycles with `sub_tick` high (default 8).
- R8: `clk_sel` copies `ctrl_q` bit 0, but changes only at a clock edge where `main_ph` and `sub_ph` are both sampled low.
- R9: `main_osc_en` is 0 exactly when `ctrl_q` bit 1 is 1 and `clk_sel` is already 1.
- R10: `lcd_clk_en` equals `sub_tick` while `stop_mode` is 0, and is 0 while `stop_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the register logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 4 | Proposed control word |
| err_clr | input | 1 | Clears the sticky write error |
| stop_mode | input | 1 | Device is in STOP; gates the LCD clock |
| main_ph | input | 1 | Main-oscillator clock phase is high |
| sub_ph | input | 1 | Sub-oscillator clock phase is high |
| sub_tick | input | 1 | One sub-oscillator period strobe |
| ctrl_q | output | 4 | Stored control word |
| clk_sel | output | 1 | Registered source select (1 = sub) |
| main_osc_en | output | 1 | Main-oscillator power enable |
| main_ready | output | 1 | Main oscillator considered stable |
| wdt_tap_sel | output | 1 | Watchdog prescaler tap (1 = /16384) |
| div_len12 | output | 1 | Divider length select (1 = 12 bits) |
| lcd_clk_en | output | 1 | LCD clock strobe from the sub-oscillator |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
The hardest case is the early return to the main clock. The main oscillator must have just been re-powered, `main_ready` must still be low, and a write must then ask for bit 0 to clear. The stimulus reaches this by first walking the legal path down to the slow clock with power off. It then writes the re-power word and, on the very next clock, writes the all-zero word. That write lands before any sub-oscillator tick can complete the stabilisation count. A reference model in the bench follows every cycle, so the randomised phase inputs also cover select hand-overs that must wait several clocks for both phases to be low.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int CW = 4;
  localparam int SEL_BIT = 0;
  localparam int OFF_BIT = 1;
  localparam int WDT_BIT = 2;
  localparam int LEN_BIT = 3;

  typedef enum logic [1:0] {
    WR_OK    = 2'd0,
    WR_HALT  = 2'd1,
    WR_BOTH  = 2'd2,
    WR_EARLY = 2'd3
  } wr_verdict_e;

  // Decide whether a proposed word may replace the stored one.
  function automatic wr_verdict_e judge_write(input logic [CW-1:0] cur,
                                              input logic [CW-1:0] nxt,
                                              input logic rdy);
    wr_verdict_e v;
    v = WR_OK;
    if (nxt[OFF_BIT] && !nxt[SEL_BIT])
      v = WR_HALT;
    else if ((nxt[SEL_BIT] != cur[SEL_BIT]) && (nxt[OFF_BIT] != cur[OFF_BIT]))
      v = WR_BOTH;
    else if (cur[SEL_BIT] && !nxt[SEL_BIT] && !rdy)
      v = WR_EARLY;
    return v;
  endfunction

  // Power-up of the main oscillator: bit 1 falls through an accepted write.
  function automatic logic is_restart(input logic [CW-1:0] cur,
                                      input logic [CW-1:0] nxt);
    return cur[OFF_BIT] && !nxt[OFF_BIT];
  endfunction

endpackage

// File: rtl/clksw_regbank.sv
module clksw_regbank
  import clksw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          err_clr,
  input  logic          main_ready,
  output logic [CW-1:0] ctrl_q,
  output logic          wr_err,
  output logic          wr_accept,
  output logic          wr_reject,
  output logic          osc_restart
);

  wr_verdict_e verdict;

  always_comb begin
    verdict     = judge_write(ctrl_q, wr_data, main_ready);
    wr_accept   = wr_en && (verdict == WR_OK);
    wr_reject   = wr_en && (verdict != WR_OK);
    osc_restart = wr_accept && is_restart(ctrl_q, wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_accept) begin
      ctrl_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_err <= 1'b0;
    end else if (wr_reject) begin
      wr_err <= 1'b1;
    end else if (err_clr) begin
      wr_err <= 1'b0;
    end
  end

endmodule

// File: rtl/clksw_stab_timer.sv
module clksw_stab_timer #(
  parameter int STAB_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic osc_off,
  input  logic sub_tick,
  output logic ready,
  output logic stab_done
);

  localparam int CNT_W = (STAB_TICKS > 1) ? $clog2(STAB_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign stab_done = !ready && !osc_off && !restart && sub_tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      cnt_q <= '0;
    end else if (restart || osc_off) begin
      ready <= 1'b0;
      cnt_q <= '0;
    end else if (stab_done) begin
      ready <= 1'b1;
    end else if (!ready && sub_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/clksw_sel_sync.sv
module clksw_sel_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_req,
  input  logic main_ph,
  input  logic sub_ph,
  output logic sel_q,
  output logic sel_move
);

  logic quiet;

  assign quiet    = !main_ph && !sub_ph;
  assign sel_move = quiet && (sel_req != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_move) begin
      sel_q <= sel_req;
    end
  end

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int STAB_TICKS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          err_clr,
  input  logic          stop_mode,
  input  logic          main_ph,
  input  logic          sub_ph,
  input  logic          sub_tick,
  output logic [CW-1:0] ctrl_q,
  output logic          clk_sel,
  output logic          main_osc_en,
  output logic          main_ready,
  output logic          wdt_tap_sel,
  output logic          div_len12,
  output logic          lcd_clk_en,
  output logic          wr_err
);

  logic wr_accept;
  logic wr_reject;
  logic osc_restart;
  logic stab_done;
  logic sel_move;

  clksw_regbank u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .err_clr     (err_clr),
    .main_ready  (main_ready),
    .ctrl_q      (ctrl_q),
    .wr_err      (wr_err),
    .wr_accept   (wr_accept),
    .wr_reject   (wr_reject),
    .osc_restart (osc_restart)
  );

  clksw_stab_timer #(.STAB_TICKS(STAB_TICKS)) u_stab (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (osc_restart),
    .osc_off   (ctrl_q[OFF_BIT]),
    .sub_tick  (sub_tick),
    .ready     (main_ready),
    .stab_done (stab_done)
  );

  clksw_sel_sync u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_req  (ctrl_q[SEL_BIT]),
    .main_ph  (main_ph),
    .sub_ph   (sub_ph),
    .sel_q    (clk_sel),
    .sel_move (sel_move)
  );

  // Power-down waits until the multiplexer has really left the main clock.
  assign main_osc_en = !(ctrl_q[OFF_BIT] && clk_sel);
  assign wdt_tap_sel = ctrl_q[WDT_BIT];
  assign div_len12   = ctrl_q[LEN_BIT];
  assign lcd_clk_en  = sub_tick && !stop_mode;

endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk
  import clksw_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] wr_data,
  input logic          err_clr,
  input logic          main_ph,
  input logic          sub_ph,
  input logic [CW-1:0] ctrl_q,
  input logic          clk_sel,
  input logic          main_osc_en,
  input logic          main_ready,
  input logic          wr_err,
  input logic          wr_accept,
  input logic          wr_reject
);

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (ctrl_q == $past(wr_data)));                                      // R2
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(ctrl_q));                                                 // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !err_clr) |=> wr_err);                                               // R3
  AST_NO_DOUBLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[SEL_BIT] != $past(ctrl_q[SEL_BIT])) |-> (ctrl_q[OFF_BIT] == $past(ctrl_q[OFF_BIT]))); // R4
  AST_NO_HALT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q[OFF_BIT] && !ctrl_q[SEL_BIT]));                                        // R5
  AST_RETURN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[SEL_BIT]) |-> $past(main_ready));                                  // R6
  AST_SEL_QUIET_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != $past(clk_sel)) |-> ($past(!main_ph) && $past(!sub_ph)));           // R8
  AST_MAIN_OFF_ON_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en |-> clk_sel);                                                      // R9

endmodule

bind clksw_ctrl clksw_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_data     (wr_data),
  .err_clr     (err_clr),
  .main_ph     (main_ph),
  .sub_ph      (sub_ph),
  .ctrl_q      (ctrl_q),
  .clk_sel     (clk_sel),
  .main_osc_en (main_osc_en),
  .main_ready  (main_ready),
  .wr_err      (wr_err),
  .wr_accept   (wr_accept),
  .wr_reject   (wr_reject)
);

// File: tb/clksw_ctrl_tb.sv
module clksw_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STAB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic       err_clr = 1'b0;
  logic       stop_mode = 1'b0;
  logic       main_ph = 1'b0;
  logic       sub_ph = 1'b0;
  logic       sub_tick = 1'b0;
  logic [3:0] ctrl_q;
  logic       clk_sel, main_osc_en, main_ready, wdt_tap_sel, div_len12, lcd_clk_en, wr_err;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference state
  int m_ctrl = 0, m_err = 0, m_rdy = 1, m_cnt = 0, m_sel = 0;

  clksw_ctrl #(.STAB_TICKS(STAB)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr),
    .stop_mode(stop_mode), .main_ph(main_ph), .sub_ph(sub_ph), .sub_tick(sub_tick),
    .ctrl_q(ctrl_q), .clk_sel(clk_sel), .main_osc_en(main_osc_en), .main_ready(main_ready),
    .wdt_tap_sel(wdt_tap_sel), .div_len12(div_len12), .lcd_clk_en(lcd_clk_en), .wr_err(wr_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Reference model: one step per rising edge, from the rules in the brief.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_err = 0; m_rdy = 1; m_cnt = 0; m_sel = 0;
    end else begin
      int  old_c;
      int  nw;
      bit  legal, accept, reject;
      old_c = m_ctrl;
      nw    = int'(wr_data);
      legal = 1;
      if ((nw & 3) == 2) legal = 0;
      if (((nw ^ old_c) & 3) == 3) legal = 0;
      if ((old_c & 1) == 1 && (nw & 1) == 0 && m_rdy == 0) legal = 0;
      accept = wr_en && legal;
      reject = wr_en && !legal;
      if (!main_ph && !sub_ph) m_sel = old_c & 1;
      if (accept && (old_c & 2) != 0 && (nw & 2) == 0) begin
        m_rdy = 0; m_cnt = 0;
      end else if ((old_c & 2) != 0) begin
        m_rdy = 0; m_cnt = 0;
      end else if (m_rdy == 0 && sub_tick) begin
        if (m_cnt == STAB - 1) m_rdy = 1;
        else m_cnt++;
      end
      if (reject) m_err = 1;
      else if (err_clr) m_err = 0;
      if (accept) m_ctrl = nw;
    end
  end

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 ctrl_q", int'(ctrl_q), m_ctrl);
      chk("R2 wdt_tap_sel", int'(wdt_tap_sel), (m_ctrl >> 2) & 1);
      chk("R2 div_len12", int'(div_len12), (m_ctrl >> 3) & 1);
      chk("R3 wr_err", int'(wr_err), m_err);
      chk("R7 main_ready", int'(main_ready), m_rdy);
      chk("R8 clk_sel", int'(clk_sel), m_sel);
      chk("R9 main_osc_en", int'(main_osc_en), ((m_ctrl & 2) != 0 && m_sel == 1) ? 0 : 1);
      chk("R10 lcd_clk_en", int'(lcd_clk_en), (sub_tick && !stop_mode) ? 1 : 0);
    end
  end

  // Background clock-phase and tick stimulus.
  always @(posedge clk) begin
    #1;
    main_ph  = 1'($urandom_range(0, 1));
    sub_ph   = ($urandom_range(0, 3) == 0);
    sub_tick = 1'($urandom_range(0, 1));
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] v, input bit clr);
    wr_en = 1'b1; wr_data = v; err_clr = clr;
    @(posedge clk); #2;
    wr_en = 1'b0; err_clr = 1'b0;
  endtask

  task automatic clear_err();
    err_clr = 1'b1;
    @(posedge clk); #2;
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl_q", int'(ctrl_q), 0);
    chk("R1 reset clk_sel", int'(clk_sel), 0);
    chk("R1 reset main_osc_en", int'(main_osc_en), 1);
    chk("R1 reset main_ready", int'(main_ready), 1);
    chk("R1 reset wr_err", int'(wr_err), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    idle(2);

    wr(4'b0100, 0);
    chk("R2 watchdog tap", int'(wdt_tap_sel), 1);
    wr(4'b1100, 0);
    chk("R2 length select", int'(div_len12), 1);

    wr(4'b1110, 0);
    chk("R5 halt pattern ctrl kept", int'(ctrl_q), 12);
    chk("R5 halt pattern error", int'(wr_err), 1);
    clear_err();
    chk("R3 error cleared", int'(wr_err), 0);

    wr(4'b1111, 0);
    chk("R4 double flip ctrl kept", int'(ctrl_q), 12);
    chk("R4 double flip error", int'(wr_err), 1);
    clear_err();
    wr(4'b1111, 1);
    chk("R3 reject beats clear", int'(wr_err), 1);
    clear_err();

    wr(4'b0001, 0);
    idle(25);
    chk("R8 select reached sub", int'(clk_sel), 1);
    wr(4'b0011, 0);
    idle(3);
    chk("R9 main powered down", int'(main_osc_en), 0);
    chk("R7 ready low while off", int'(main_ready), 0);

    wr(4'b0000, 0);
    chk("R4 direct return refused", int'(ctrl_q), 3);
    clear_err();

    wr(4'b0001, 0);
    chk("R7 restart clears ready", int'(main_ready), 0);
    wr(4'b0000, 0);
    chk("R6 early return ctrl kept", int'(ctrl_q), 1);
    chk("R6 early return error", int'(wr_err), 1);
    clear_err();

    idle(80);
    chk("R7 ready after stabilisation", int'(main_ready), 1);
    wr(4'b0000, 0);
    chk("R6 return accepted when ready", int'(ctrl_q), 0);
    idle(25);
    chk("R8 select back on main", int'(clk_sel), 0);

    stop_mode = 1'b1;
    idle(10);
    stop_mode = 1'b0;
    idle(10);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule